// File: doc/BRIEF.md
# SDRAM Power-State and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It drives the clock-enable pin and the four active-low command pins for every transition that clock-enable governs: auto-refresh, self refresh, power down and clock suspend. It keeps a model of where the memory is: idle, bank active, suspended, refreshing, in self refresh, powered down, or waiting after a self-refresh exit. It also checks each host request against that model before it acts on it.

A host asks for an operation through a valid/ready handshake that carries a 3-bit operation code. Requests that the current state permits are turned into the correct pin sequence one cycle after they are accepted. Requests that it does not permit raise a one-cycle error pulse and change nothing. The bank activation logic reports whether any bank is open through a level input. A wrapping counter records how many auto-refresh commands have been issued and pulses once for each full pass over the array.

Top module: `sdram_pwr_seq`

## Requirements
- R1: While reset is asserted and after it is released, clock-enable is high, the pins carry NOP (command nibble {cs_n,ras_n,cas_n,we_n} = 4'b0111), the state is IDLE (code 0), the refresh count is 0 and req_ready is high.
- R2: When no request is accepted and the state is IDLE or ACTIVE, the state becomes ACTIVE (code 1) one cycle after banks_open is high and IDLE one cycle after it is low.
- R3: req_ready is low and busy is high exactly while the state is REFRESH (code 3) or EXIT_WAIT (code 6). A request is taken only in a cycle where req_valid and req_ready are both high.
- R4: Op code 1 (auto-refresh) is legal only in IDLE with banks_open low. In the cycle after acceptance, the pins show 4'b0001 for one cycle with clock-enable high.
- R5: Each accepted auto-refresh increments ref_count, which wraps to 0 after REF_TOTAL (default 2048) commands. ref_pass is high for one cycle, together with the wrapped count of 0.
- R6: After an auto-refresh the state is REFRESH for TRFC_CYC cycles and then returns to IDLE. Only NOP is issued during this time, and no precharge.
- R7: Op code 2 (self-refresh entry) is legal only in IDLE with banks_open low. In the cycle after acceptance, the pins show 4'b0001 with clock-enable low, and the state becomes SELF (code 4).
- R8: In SELF, clock-enable stays low and only NOP is driven, for as long as no exit is requested.
- R9: Op code 3 (self-refresh exit) is legal only in SELF. It raises clock-enable with NOP, holds EXIT_WAIT for TXSR_CYC cycles and then returns to IDLE.
- R10: Op code 4 (power-down entry) is legal only in IDLE with banks_open low. It lowers clock-enable with NOP and enters POWER_DOWN (code 5). Op code 5 is legal only in POWER_DOWN, and it raises clock-enable and returns to IDLE.
- R11: Op code 6 (suspend entry) is legal only in ACTIVE. It lowers clock-enable and enters SUSPEND (code 2). While suspended, banks_open is ignored. Op code 7 is legal only in SUSPEND, and it raises clock-enable and returns to ACTIVE.
- R12: An accepted request that is op code 0, or whose precondition fails, raises req_err for exactly one cycle. The pins then carry NOP, clock-enable is unchanged, and the state changes only as R2 allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_op | input | 3 | Requested operation code |
| req_ready | output | 1 | Sequencer can take a request |
| banks_open | input | 1 | High while any bank is activated |
| busy | output | 1 | Timed wait in progress |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| mem_cke | output | 1 | SDRAM clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| state_o | output | 3 | Tracked memory state code |
| ref_count | output | 11 | Auto-refresh commands issued, modulo REF_TOTAL |
| ref_pass | output | 1 | One-cycle pulse when the count wraps |

## Verification
The bench first issues legal requests from the wrong state: refresh and self-refresh entry with a bank open, suspend entry from idle, and exits from states that were never entered. A sequencer that skipped a precondition would put a refresh or a clock-enable edge on the pins instead of raising the error pulse. While the memory is suspended, it drops banks_open. A design that kept tracking that input would slip back to idle and lose the open row. It runs the full 2048-refresh pass and checks the wrap pulse on the last command exactly. It also counts the busy windows after refresh and after self-refresh exit cycle by cycle, so that an off-by-one in either timer shows up as a wrong state or a ready asserted early.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_REFRESH = 3'd1,
    OP_SR_IN   = 3'd2,
    OP_SR_OUT  = 3'd3,
    OP_PD_IN   = 3'd4,
    OP_PD_OUT  = 3'd5,
    OP_SUS_IN  = 3'd6,
    OP_SUS_OUT = 3'd7
  } pwr_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACT   = 3'd1,
    ST_SUSP  = 3'd2,
    ST_REF   = 3'd3,
    ST_SELF  = 3'd4,
    ST_PDN   = 3'd5,
    ST_XWAIT = 3'd6
  } pwr_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pin_cmd_t CMD_REFR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/pwr_req_check.sv
module pwr_req_check
  import sdram_pwr_pkg::*;
(
  input  pwr_st_e st,
  input  pwr_op_e op,
  input  logic    banks_open,
  output logic    legal,
  output pwr_st_e nxt_st,
  output logic    nxt_cke,
  output logic    refr_pins,
  output logic    wait_load,
  output logic    wait_exit,
  output logic    count_step
);

  logic idle_closed;
  assign idle_closed = (st == ST_IDLE) && !banks_open;

  always_comb begin
    legal      = 1'b0;
    nxt_st     = st;
    nxt_cke    = 1'b1;
    refr_pins  = 1'b0;
    wait_load  = 1'b0;
    wait_exit  = 1'b0;
    count_step = 1'b0;
    case (op)
      OP_REFRESH: begin
        legal      = idle_closed;
        nxt_st     = ST_REF;
        refr_pins  = 1'b1;
        wait_load  = 1'b1;
        count_step = 1'b1;
      end
      OP_SR_IN: begin
        legal     = idle_closed;
        nxt_st    = ST_SELF;
        nxt_cke   = 1'b0;
        refr_pins = 1'b1;
      end
      OP_SR_OUT: begin
        legal     = (st == ST_SELF);
        nxt_st    = ST_XWAIT;
        wait_load = 1'b1;
        wait_exit = 1'b1;
      end
      OP_PD_IN: begin
        legal   = idle_closed;
        nxt_st  = ST_PDN;
        nxt_cke = 1'b0;
      end
      OP_PD_OUT: begin
        legal  = (st == ST_PDN);
        nxt_st = ST_IDLE;
      end
      OP_SUS_IN: begin
        legal   = (st == ST_ACT);
        nxt_st  = ST_SUSP;
        nxt_cke = 1'b0;
      end
      OP_SUS_OUT: begin
        legal  = (st == ST_SUSP);
        nxt_st = ST_ACT;
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == W'(1));

endmodule

// File: rtl/pwr_ref_tally.sv
module pwr_ref_tally #(
  parameter int TOTAL = 2048,
  localparam int CW = (TOTAL > 2) ? $clog2(TOTAL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          pass
);

  logic [CW-1:0] cnt_q, cnt_inc;
  logic          at_last;
  logic          pass_q;

  assign at_last = (cnt_q == CW'(TOTAL - 1));

  generate
    if ((TOTAL & (TOTAL - 1)) == 0) begin : g_pow2
      assign cnt_inc = cnt_q + CW'(1);
    end else begin : g_mod
      assign cnt_inc = at_last ? '0 : cnt_q + CW'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      pass_q <= step && at_last;
      if (step) cnt_q <= cnt_inc;
    end
  end

  assign count = cnt_q;
  assign pass  = pass_q;

endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdram_pwr_pkg::*;
#(
  parameter int REF_TOTAL = 2048,
  parameter int TRFC_CYC  = 4,
  parameter int TXSR_CYC  = 6,
  localparam int CW = $clog2(REF_TOTAL),
  localparam int TMAX = (TRFC_CYC > TXSR_CYC) ? TRFC_CYC : TXSR_CYC,
  localparam int TW = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  output logic          req_ready,
  input  logic          banks_open,
  output logic          busy,
  output logic          req_err,
  output logic          mem_cke,
  output logic          mem_cs_n,
  output logic          mem_ras_n,
  output logic          mem_cas_n,
  output logic          mem_we_n,
  output logic [2:0]    state_o,
  output logic [CW-1:0] ref_count,
  output logic          ref_pass
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pwr_st_e  st_q, st_d;
  logic     cke_q, cke_d;
  pin_cmd_t cmd_q, cmd_d;
  logic     err_q, err_d;
  logic     fire;

  logic     ck_legal, ck_cke, ck_refr, ck_load, ck_exit, ck_step;
  pwr_st_e  ck_nxt;
  logic     tmr_load, tmr_expire;
  logic [TW-1:0] tmr_val;
  logic     tally_step;

  assign req_ready = (st_q != ST_REF) && (st_q != ST_XWAIT);
  assign busy      = !req_ready;
  assign fire      = req_valid && req_ready;

  pwr_req_check u_check (
    .st         (st_q),
    .op         (pwr_op_e'(req_op)),
    .banks_open (banks_open),
    .legal      (ck_legal),
    .nxt_st     (ck_nxt),
    .nxt_cke    (ck_cke),
    .refr_pins  (ck_refr),
    .wait_load  (ck_load),
    .wait_exit  (ck_exit),
    .count_step (ck_step)
  );

  always_comb begin
    st_d       = st_q;
    cke_d      = cke_q;
    cmd_d      = CMD_NOP;
    err_d      = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = TW'(TRFC_CYC);
    tally_step = 1'b0;

    case (st_q)
      ST_IDLE, ST_ACT: st_d = banks_open ? ST_ACT : ST_IDLE;
      ST_REF, ST_XWAIT: if (tmr_expire) st_d = ST_IDLE;
      default: st_d = st_q;
    endcase

    if (fire) begin
      if (ck_legal) begin
        st_d       = ck_nxt;
        cke_d      = ck_cke;
        if (ck_refr) cmd_d = CMD_REFR;
        tmr_load   = ck_load;
        tmr_val    = ck_exit ? TW'(TXSR_CYC) : TW'(TRFC_CYC);
        tally_step = ck_step;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q  <= ST_IDLE;
      cke_q <= 1'b1;
      cmd_q <= CMD_NOP;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cke_q <= cke_d;
      cmd_q <= cmd_d;
      err_q <= err_d;
    end
  end

  pwr_wait_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  pwr_ref_tally #(.TOTAL(REF_TOTAL)) u_tally (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (tally_step),
    .count (ref_count),
    .pass  (ref_pass)
  );

  assign req_err   = err_q;
  assign mem_cke   = cke_q;
  assign mem_cs_n  = cmd_q.cs_n;
  assign mem_ras_n = cmd_q.ras_n;
  assign mem_cas_n = cmd_q.cas_n;
  assign mem_we_n  = cmd_q.we_n;
  assign state_o   = st_q;

endmodule

// File: rtl/sdram_pwr_seq_chk.sv
module sdram_pwr_seq_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          banks_open,
  input logic          req_err,
  input logic          mem_cke,
  input logic          mem_cs_n,
  input logic          mem_ras_n,
  input logic          mem_cas_n,
  input logic          mem_we_n,
  input logic [2:0]    state_o,
  input logic [CW-1:0] ref_count,
  input logic          ref_pass
);

  logic refr_pins;
  assign refr_pins = !mem_cs_n && !mem_ras_n && !mem_cas_n && mem_we_n;

  assert_refresh_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refr_pins && mem_cke && $past(mem_cke)) |-> ($past(state_o) == 3'd0 && !$past(banks_open)));

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pass |-> (ref_count == '0));

  assert_refresh_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3) |=> (state_o == 3'd3 || state_o == 3'd0));

  assert_self_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cke) && refr_pins) |-> ($past(state_o) == 3'd0));

  assert_self_cke_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4) |-> !mem_cke);

  assert_suspend_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cke) && state_o == 3'd2) |-> ($past(state_o) == 3'd1));

  assert_suspend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2) |=> (state_o == 3'd2 || state_o == 3'd1));

  assert_err_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid && req_ready));

endmodule

bind sdram_pwr_seq sdram_pwr_seq_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .banks_open (banks_open),
  .req_err    (req_err),
  .mem_cke    (mem_cke),
  .mem_cs_n   (mem_cs_n),
  .mem_ras_n  (mem_ras_n),
  .mem_cas_n  (mem_cas_n),
  .mem_we_n   (mem_we_n),
  .state_o    (state_o),
  .ref_count  (ref_count),
  .ref_pass   (ref_pass)
);

// File: tb/sdram_pwr_seq_bench.sv
`timescale 1ns/1ps
module sdram_pwr_seq_bench;

  localparam int TRFC = 4;
  localparam int TXSR = 6;
  localparam int RTOT = 2048;
  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_REF = 4'b0001;

  logic clk, rst_n, req_valid, banks_open;
  logic [2:0] req_op;
  logic req_ready, busy, req_err, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [2:0] state_o;
  logic [10:0] ref_count;
  logic ref_pass;

  sdram_pwr_seq #(.REF_TOTAL(RTOT), .TRFC_CYC(TRFC), .TXSR_CYC(TXSR)) u_sdram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_ready(req_ready),
    .banks_open(banks_open), .busy(busy), .req_err(req_err), .mem_cke(mem_cke),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .state_o(state_o), .ref_count(ref_count), .ref_pass(ref_pass));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        cke;
    logic [3:0]  cmd;
    logic        rdy;
    logic        bsy;
    logic        err;
    logic [2:0]  st;
    logic [10:0] cnt;
    logic        wrap;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;
  logic       mcke;
  int         mcnt;
  logic [2:0] mst;

  function automatic obs_t now_obs();
    obs_t o;
    o.cke = mem_cke; o.cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    o.rdy = req_ready; o.bsy = busy; o.err = req_err; o.st = state_o;
    o.cnt = ref_count; o.wrap = ref_pass;
    return o;
  endfunction

  task automatic put(input logic [3:0] cmd, input logic err, input logic wrap, input string tag);
    obs_t o;
    o.cke = mcke; o.cmd = cmd; o.rdy = !(mst == 3'd3 || mst == 3'd6); o.bsy = !o.rdy;
    o.err = err; o.st = mst; o.cnt = mcnt[10:0]; o.wrap = wrap;
    exp_q.push_back(o);
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      obs_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = now_obs();
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual cke=%b cmd=%b rdy=%b busy=%b err=%b st=%0d cnt=%0d wrap=%b expected cke=%b cmd=%b rdy=%b busy=%b err=%b st=%0d cnt=%0d wrap=%b",
                 t, a.cke, a.cmd, a.rdy, a.bsy, a.err, a.st, a.cnt, a.wrap,
                 e.cke, e.cmd, e.rdy, e.bsy, e.err, e.st, e.cnt, e.wrap);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
  endtask

  task automatic release_and_drain();
    @(negedge clk);
    req_valid = 1'b0;
    req_op    = 3'd0;
    drain();
  endtask

  task automatic observe(input int n, input string tag);
    @(negedge clk);
    for (int i = 0; i < n; i++) put(P_NOP, 1'b0, 1'b0, tag);
    drain();
  endtask

  task automatic do_refresh(input string tag);
    logic w;
    issue(3'd1);
    mcnt++;
    w = (mcnt == RTOT);
    if (w) mcnt = 0;
    mst = 3'd3;
    put(P_REF, 1'b0, w, tag);
    for (int i = 1; i < TRFC; i++) put(P_NOP, 1'b0, 1'b0, tag);
    mst = 3'd0;
    put(P_NOP, 1'b0, 1'b0, tag);
    release_and_drain();
  endtask

  task automatic do_err(input logic [2:0] op, input string tag);
    issue(op);
    put(P_NOP, 1'b1, 1'b0, tag);
    put(P_NOP, 1'b0, 1'b0, tag);
    release_and_drain();
  endtask

  task automatic do_move(input logic [2:0] op, input logic [2:0] nst, input logic ncke,
                         input logic [3:0] cmd, input string tag);
    issue(op);
    mst = nst; mcke = ncke;
    put(cmd, 1'b0, 1'b0, tag);
    put(P_NOP, 1'b0, 1'b0, tag);
    release_and_drain();
  endtask

  task automatic set_banks(input logic v, input string tag);
    @(negedge clk);
    banks_open = v;
    if (mst == 3'd0 || mst == 3'd1) mst = v ? 3'd1 : 3'd0;
    put(P_NOP, 1'b0, 1'b0, tag);
    drain();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual run still going expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; banks_open = 1'b0;
    mcke = 1'b1; mcnt = 0; mst = 3'd0;
    repeat (3) @(negedge clk);
    // R1 reset values while reset held
    checks++;
    if (now_obs() !== {1'b1, P_NOP, 1'b1, 1'b0, 1'b0, 3'd0, 11'd0, 1'b0}) begin
      fails++;
      $display("FAIL R1: actual %h expected reset state", now_obs());
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    observe(2, "R1");

    // R2 tracking of bank status
    set_banks(1'b1, "R2");
    observe(2, "R2");
    // R12 refresh and self entry rejected with banks open, R4 R7 preconditions
    do_err(3'd1, "R12_R4");
    do_err(3'd2, "R12_R7");
    do_err(3'd4, "R12_R10");
    // R11 suspend and ignore banks_open
    do_move(3'd6, 3'd2, 1'b0, P_NOP, "R11");
    @(negedge clk); banks_open = 1'b0;
    observe(3, "R11");
    @(negedge clk); banks_open = 1'b1;
    observe(1, "R11");
    do_err(3'd6, "R12_R11");
    do_move(3'd7, 3'd1, 1'b1, P_NOP, "R11");
    set_banks(1'b0, "R2");
    observe(1, "R2");

    // R12 illegal from idle
    do_err(3'd0, "R12");
    do_err(3'd6, "R12");
    do_err(3'd5, "R12");
    do_err(3'd3, "R12");

    // R4 R6 R3 refresh
    do_refresh("R4_R6_R3");
    do_refresh("R4_R6");

    // R7 R8 R9 self refresh
    do_move(3'd2, 3'd4, 1'b0, P_REF, "R7");
    observe(20, "R8");
    do_err(3'd1, "R12_R8");
    issue(3'd3);
    mcke = 1'b1; mst = 3'd6;
    for (int i = 0; i < TXSR; i++) put(P_NOP, 1'b0, 1'b0, "R9_R3");
    mst = 3'd0;
    put(P_NOP, 1'b0, 1'b0, "R9");
    release_and_drain();

    // R10 power down
    do_move(3'd4, 3'd5, 1'b0, P_NOP, "R10");
    observe(5, "R10");
    do_err(3'd1, "R12_R10");
    do_move(3'd5, 3'd0, 1'b1, P_NOP, "R10");

    // R5 full pass of the refresh counter
    while (mcnt != 0) do_refresh("R5");
    do_refresh("R5");
    observe(2, "R5");

    finish_run();
  end

endmodule